// File: doc/BRIEF.md
# Interrupt Input Latch and Software Interrupt Dispatcher

This block sits in front of an interrupt distributor's pending state. It watches external interrupt wires and software interrupt commands and turns them into one-cycle requests to set pending bits, one request bit per (CPU, interrupt ID) pair. It keeps the small amount of state it needs to decide whether a wire change counts. That state is the recorded level of every wire, an edge or level trigger setting per ID, enable bits, and a target CPU mask for every shared ID. Enable bits are banked per CPU for the private IDs and kept once for the shared IDs.

Interrupt IDs 0 to 31 are private: every CPU has its own 32 input wires for them, and a wire of CPU c only ever concerns CPU c. Shared wire n carries ID n+32 and is routed to the CPUs in that ID's target mask. Wires are brought through two synchronizing flops. A rising level is then acted on once. A falling level only updates the recorded level. Enables, trigger settings and targets are written through a single command port. The same port carries 32-bit software interrupt words, which select their destination CPUs through a two-bit filter.

The request vector `pend_set_o` is registered. Bit `c*NUM_IRQ + id` asks for ID `id` to become pending on CPU `c`, where `NUM_IRQ = NUM_SHARED + 32`. Priority selection, acknowledge and clearing of pending state belong to the consumer of these requests.

Top module: `irq_latch_dispatch`

## Requirements
- R1: After synchronous reset, IDs 0 to 15 are enabled on every CPU and edge-triggered. Every other ID is disabled and level-triggered, every shared target mask is zero, and every recorded level is low, so `pend_set_o` is all zero.
- R2: A rising private wire `prv_line_i[c*32+i]` raises only bit `c*NUM_IRQ+i`, three clock edges after it is first sampled (two synchronizer stages plus the registered output), provided ID i is edge-triggered or enabled on CPU c.
- R3: A rising shared wire `shr_line_i[n]` raises bit `c*NUM_IRQ+32+n` for every CPU c set in the target mask of ID n+32, with the same three-edge latency, provided that ID is edge-triggered or enabled.
- R4: A rising wire on an ID that is level-triggered and disabled raises nothing, and a falling wire never raises anything.
- R5: Only a change of a wire is acted on: a wire held high produces a single one-cycle request.
- R6: Command op 1 (enable set, ID in `cmd_id_i`, requester in `cmd_cpu_i` for private IDs) on an ID that is level-triggered and whose recorded level is high raises its request on the next edge. For a private ID the request goes to the requester only; for a shared ID it goes to every CPU in the target mask.
- R7: Command op 3 (trigger configuration) takes `cmd_data_i[1]` as the edge-trigger flag (1 = edge) and accepts `cmd_data_i[0]`, the 1:N model flag, without any effect here. A write to an ID below 32 always leaves that ID edge-triggered.
- R8: Command op 5 (software interrupt) takes its ID from `cmd_data_i[9:0]` and its filter from `cmd_data_i[25:24]`. Filter 0 targets the CPUs listed in `cmd_data_i[16 +: NUM_CPU]`, 1 all CPUs except `cmd_cpu_i`, 2 only `cmd_cpu_i`, and 3 all CPUs. The request appears on the next edge, and an ID of `NUM_IRQ` or more raises nothing.
- R9: Command op 2 (enable clear) disables the ID (on the requester only, for private IDs), so a later rise on a level-triggered ID raises nothing.
- R10: Command op 4 (target write) sets the target mask of a shared ID from `cmd_data_i[NUM_CPU-1:0]`. Op 0 and ops 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shr_line_i | input | NUM_SHARED (32) | Shared interrupt wires, wire n carries ID n+32 |
| prv_line_i | input | NUM_CPU*32 (128) | Private interrupt wires, bit c*32+i is ID i of CPU c |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle |
| cmd_op_i | input | 3 | 1 enable set, 2 enable clear, 3 trigger config, 4 target write, 5 software interrupt |
| cmd_cpu_i | input | CPU_W (2) | Requesting CPU |
| cmd_id_i | input | ID_W (6) | Interrupt ID for ops 1 to 4 |
| cmd_data_i | input | 32 | Config bits, target mask or software interrupt word |
| pend_set_o | output | NUM_CPU*NUM_IRQ (256) | One-cycle pending-set requests, bit c*NUM_IRQ+id |

## Verification
The assertions take for granted that the wires are driven from a single clock domain or change slowly enough for the two-flop synchronizer. They also assume `cmd_cpu_i` names an existing CPU whenever a software interrupt is issued. The quiet-output property further assumes that a request can only come from a wire change or a command, so the stimulus issues each command or wire change on its own and leaves several idle cycles afterwards. Enable-set commands are never issued in the same cycle as a rising edge on the same ID, because that case is resolved from the state held before the edge.

// File: rtl/irq_ld_pkg.sv
// Package: irq_ld_pkg
// Shared constants and command encodings for the interrupt input latch.
// Assumes a 32-bit software interrupt word and 32 private IDs per CPU.
package irq_ld_pkg;

    localparam int PRIV_IDS     = 32;  // IDs 0..31 are per-CPU
    localparam int RESET_ON_IDS = 16;  // IDs 0..15 enabled and edge at reset
    localparam int CMD_W        = 32;
    localparam int CFG_EDGE_BIT = 1;
    localparam int SGI_ID_MSB   = 9;
    localparam int SGI_LIST_LSB = 16;
    localparam int SGI_FILT_LSB = 24;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_EN_SET = 3'd1,
        OP_EN_CLR = 3'd2,
        OP_CFG    = 3'd3,
        OP_TGT    = 3'd4,
        OP_SGI    = 3'd5
    } cmd_op_e;

    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_ALL    = 2'd3
    } sgi_filter_e;

endpackage

// File: rtl/irq_line_sync.sv
// Module: irq_line_sync
// Brings a bundle of interrupt wires through two flops and keeps the
// last recorded level of each wire; a rise is reported for one cycle.
// Assumes nothing about the wires' source clock beyond two-flop safety.
module irq_line_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] line_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] level_q;

    // Two-stage synchronizer followed by the recorded level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q  <= '0;
            sync_q  <= '0;
            level_q <= '0;
        end else begin
            meta_q  <= line_i;
            sync_q  <= meta_q;
            level_q <= sync_q;
        end
    end

    assign rise_o  = sync_q & ~level_q;
    assign level_o = level_q;

endmodule

// File: rtl/irq_cfg_store.sv
// Module: irq_cfg_store
// Holds enables (banked per CPU for private IDs), trigger mode per ID
// and the target CPU mask of each shared ID, written by commands.
// Assumes at most one command per cycle; out-of-range IDs are ignored.
module irq_cfg_store
    import irq_ld_pkg::*;
#(
    parameter int NUM_CPU    = 4,
    parameter int NUM_SHARED = 32,
    parameter int CPU_W      = 2,
    parameter int ID_W       = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid_i,
    input  logic [2:0]                    cmd_op_i,
    input  logic [CPU_W-1:0]              cmd_cpu_i,
    input  logic [ID_W-1:0]               cmd_id_i,
    input  logic                          cfg_edge_i,
    input  logic [NUM_CPU-1:0]            tgt_mask_i,
    output logic [NUM_CPU*PRIV_IDS-1:0]   en_prv_o,
    output logic [NUM_SHARED-1:0]         en_shr_o,
    output logic [NUM_SHARED+PRIV_IDS-1:0] trig_o,
    output logic [NUM_SHARED*NUM_CPU-1:0] tgt_o
);

    localparam int NUM_IRQ = NUM_SHARED + PRIV_IDS;
    localparam logic [PRIV_IDS-1:0] PRV_RST_EN =
        {{(PRIV_IDS-RESET_ON_IDS){1'b0}}, {RESET_ON_IDS{1'b1}}};
    localparam logic [NUM_IRQ-1:0] TRIG_RST =
        {{(NUM_IRQ-RESET_ON_IDS){1'b0}}, {RESET_ON_IDS{1'b1}}};

    logic [NUM_CPU*PRIV_IDS-1:0]    en_prv_q;
    logic [NUM_SHARED-1:0]          en_shr_q;
    logic [NUM_IRQ-1:0]             trig_q;
    logic [NUM_SHARED*NUM_CPU-1:0]  tgt_q;

    int  id_int;
    int  cpu_int;
    logic cpu_ok;

    // Command field decode into integer indices
    always_comb begin
        id_int  = int'(cmd_id_i);
        cpu_int = int'(cmd_cpu_i);
        cpu_ok  = cpu_int < NUM_CPU;
    end

    // Apply one configuration command per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prv_q <= {NUM_CPU{PRV_RST_EN}};
            en_shr_q <= '0;
            trig_q   <= TRIG_RST;
            tgt_q    <= '0;
        end else if (cmd_valid_i) begin
            case (cmd_op_i)
                OP_EN_SET, OP_EN_CLR: begin
                    if (id_int < PRIV_IDS) begin
                        if (cpu_ok)
                            en_prv_q[cpu_int*PRIV_IDS + id_int] <= (cmd_op_i == OP_EN_SET);
                    end else if (id_int < NUM_IRQ) begin
                        en_shr_q[id_int - PRIV_IDS] <= (cmd_op_i == OP_EN_SET);
                    end
                end
                OP_CFG: begin
                    if (id_int < PRIV_IDS)
                        trig_q[id_int] <= 1'b1;
                    else if (id_int < NUM_IRQ)
                        trig_q[id_int] <= cfg_edge_i;
                end
                OP_TGT: begin
                    if (id_int >= PRIV_IDS && id_int < NUM_IRQ)
                        tgt_q[(id_int-PRIV_IDS)*NUM_CPU +: NUM_CPU] <= tgt_mask_i;
                end
                default: ;
            endcase
        end
    end

    assign en_prv_o = en_prv_q;
    assign en_shr_o = en_shr_q;
    assign trig_o   = trig_q;
    assign tgt_o    = tgt_q;

endmodule

// File: rtl/irq_sgi_decode.sv
// Module: irq_sgi_decode
// Decodes a software interrupt word into an ID, a validity flag and
// the destination CPU mask according to its two-bit filter.
// Assumes the requesting CPU index is supplied with the word.
module irq_sgi_decode
    import irq_ld_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_IRQ = 64,
    parameter int CPU_W   = 2,
    parameter int ID_W    = 6
) (
    input  logic [CMD_W-1:0]   word_i,
    input  logic [CPU_W-1:0]   req_cpu_i,
    output logic               id_ok_o,
    output logic [ID_W-1:0]    id_o,
    output logic [NUM_CPU-1:0] mask_o
);

    localparam logic [CMD_W-1:0] USED_BITS =
        (32'h1 << (SGI_ID_MSB+1)) - 32'h1
        | (((32'h1 << NUM_CPU) - 32'h1) << SGI_LIST_LSB)
        | (32'h3 << SGI_FILT_LSB);

    logic [NUM_CPU-1:0] self_mask;
    logic               sgi_word_unused;

    // Requester one-hot and filter selection
    always_comb begin
        self_mask = '0;
        if (int'(req_cpu_i) < NUM_CPU)
            self_mask[req_cpu_i] = 1'b1;
        case (sgi_filter_e'(word_i[SGI_FILT_LSB +: 2]))
            FLT_LIST:   mask_o = word_i[SGI_LIST_LSB +: NUM_CPU];
            FLT_OTHERS: mask_o = ~self_mask;
            FLT_SELF:   mask_o = self_mask;
            default:    mask_o = '1;
        endcase
    end

    assign id_ok_o         = int'(word_i[SGI_ID_MSB:0]) < NUM_IRQ;
    assign id_o            = word_i[ID_W-1:0];
    assign sgi_word_unused = ^(word_i & ~USED_BITS);

endmodule

// File: rtl/irq_latch_dispatch.sv
// Module: irq_latch_dispatch (top)
// Turns interrupt wire rises and software interrupt commands into
// registered one-cycle pending-set requests, bit cpu*NUM_IRQ + id.
// Assumes one command per cycle and wires safe for a two-flop sync.
module irq_latch_dispatch
    import irq_ld_pkg::*;
#(
    parameter int NUM_CPU    = 4,
    parameter int NUM_SHARED = 32,
    parameter int NUM_IRQ    = NUM_SHARED + PRIV_IDS,
    parameter int CPU_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    parameter int ID_W       = $clog2(NUM_IRQ)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SHARED-1:0]       shr_line_i,
    input  logic [NUM_CPU*PRIV_IDS-1:0] prv_line_i,
    input  logic                        cmd_valid_i,
    input  logic [2:0]                  cmd_op_i,
    input  logic [CPU_W-1:0]            cmd_cpu_i,
    input  logic [ID_W-1:0]             cmd_id_i,
    input  logic [CMD_W-1:0]            cmd_data_i,
    output logic [NUM_CPU*NUM_IRQ-1:0]  pend_set_o
);

    localparam int OUT_W = NUM_CPU * NUM_IRQ;

    logic [NUM_SHARED-1:0]         shr_lvl, shr_rise;
    logic [NUM_CPU*PRIV_IDS-1:0]   prv_lvl, prv_rise;
    logic [NUM_CPU*PRIV_IDS-1:0]   en_prv;
    logic [NUM_SHARED-1:0]         en_shr;
    logic [NUM_IRQ-1:0]            trig;
    logic [NUM_SHARED*NUM_CPU-1:0] tgt;
    logic                          sgi_id_ok;
    logic [ID_W-1:0]               sgi_id;
    logic [NUM_CPU-1:0]            sgi_mask;
    logic [OUT_W-1:0]              line_req, en_lvl_req, sgi_req, pend_q;

    irq_line_sync #(.WIDTH(NUM_SHARED)) u_shr_sync (
        .clk(clk), .rst_n(rst_n), .line_i(shr_line_i),
        .level_o(shr_lvl), .rise_o(shr_rise)
    );

    irq_line_sync #(.WIDTH(NUM_CPU*PRIV_IDS)) u_prv_sync (
        .clk(clk), .rst_n(rst_n), .line_i(prv_line_i),
        .level_o(prv_lvl), .rise_o(prv_rise)
    );

    irq_cfg_store #(
        .NUM_CPU(NUM_CPU), .NUM_SHARED(NUM_SHARED), .CPU_W(CPU_W), .ID_W(ID_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
        .cmd_cpu_i(cmd_cpu_i), .cmd_id_i(cmd_id_i),
        .cfg_edge_i(cmd_data_i[CFG_EDGE_BIT]),
        .tgt_mask_i(cmd_data_i[NUM_CPU-1:0]),
        .en_prv_o(en_prv), .en_shr_o(en_shr), .trig_o(trig), .tgt_o(tgt)
    );

    irq_sgi_decode #(
        .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W), .ID_W(ID_W)
    ) u_sgi (
        .word_i(cmd_data_i), .req_cpu_i(cmd_cpu_i),
        .id_ok_o(sgi_id_ok), .id_o(sgi_id), .mask_o(sgi_mask)
    );

    // Per-CPU request bits from wire rises (private and shared)
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar i = 0; i < PRIV_IDS; i++) begin : g_prv
            assign line_req[c*NUM_IRQ + i] =
                prv_rise[c*PRIV_IDS + i] & (trig[i] | en_prv[c*PRIV_IDS + i]);
        end
        for (genvar n = 0; n < NUM_SHARED; n++) begin : g_shr
            assign line_req[c*NUM_IRQ + PRIV_IDS + n] =
                shr_rise[n] & (trig[PRIV_IDS + n] | en_shr[n]) & tgt[n*NUM_CPU + c];
        end
    end

    // Enable-set on a level-triggered ID whose recorded level is high
    always_comb begin
        int id_v;
        int cpu_v;
        en_lvl_req = '0;
        id_v  = int'(cmd_id_i);
        cpu_v = int'(cmd_cpu_i);
        if (cmd_valid_i && cmd_op_i == OP_EN_SET && id_v < NUM_IRQ && !trig[id_v]) begin
            if (id_v < PRIV_IDS) begin
                if (cpu_v < NUM_CPU && prv_lvl[cpu_v*PRIV_IDS + id_v])
                    en_lvl_req[cpu_v*NUM_IRQ + id_v] = 1'b1;
            end else if (shr_lvl[id_v - PRIV_IDS]) begin
                for (int c = 0; c < NUM_CPU; c++)
                    if (tgt[(id_v-PRIV_IDS)*NUM_CPU + c])
                        en_lvl_req[c*NUM_IRQ + id_v] = 1'b1;
            end
        end
    end

    // Software interrupt expansion over the destination mask
    always_comb begin
        sgi_req = '0;
        if (cmd_valid_i && cmd_op_i == OP_SGI && sgi_id_ok) begin
            for (int c = 0; c < NUM_CPU; c++)
                if (sgi_mask[c])
                    sgi_req[c*NUM_IRQ + int'(sgi_id)] = 1'b1;
        end
    end

    // Registered one-cycle request output
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= line_req | en_lvl_req | sgi_req;
    end

    assign pend_set_o = pend_q;

endmodule

// File: rtl/irq_latch_dispatch_chk.sv
// Module: irq_latch_dispatch_chk
// Port-level properties of irq_latch_dispatch, attached by bind.
// Assumes wires only reach the output through the three-edge path.
module irq_latch_dispatch_chk
    import irq_ld_pkg::*;
#(
    parameter int NUM_CPU    = 4,
    parameter int NUM_SHARED = 32,
    parameter int NUM_IRQ    = 64,
    parameter int CPU_W      = 2,
    parameter int ID_W       = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_SHARED-1:0]       shr_line_i,
    input logic [NUM_CPU*PRIV_IDS-1:0] prv_line_i,
    input logic                        cmd_valid_i,
    input logic [2:0]                  cmd_op_i,
    input logic [CPU_W-1:0]            cmd_cpu_i,
    input logic [ID_W-1:0]             cmd_id_i,
    input logic [CMD_W-1:0]            cmd_data_i,
    input logic [NUM_CPU*NUM_IRQ-1:0]  pend_set_o
);

    logic [2:0] settle_q;
    logic       sgi_ok;

    // Count cycles since reset so line history is post-reset only
    always_ff @(posedge clk) begin
        if (!rst_n)
            settle_q <= '0;
        else if (settle_q != 3'd7)
            settle_q <= settle_q + 3'd1;
    end

    assign sgi_ok = cmd_valid_i && cmd_op_i == OP_SGI
                    && int'(cmd_data_i[SGI_ID_MSB:0]) < NUM_IRQ
                    && int'(cmd_cpu_i) < NUM_CPU;

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pend_set_o == '0);

    a_r4_no_cause_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q >= 3'd6 && !$past(cmd_valid_i)
         && $past(shr_line_i, 3) == $past(shr_line_i, 4)
         && $past(prv_line_i, 3) == $past(prv_line_i, 4))
        |-> pend_set_o == '0);

    a_r8_self_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (sgi_ok && cmd_data_i[SGI_FILT_LSB +: 2] == 2'd2)
        |=> pend_set_o[int'($past(cmd_cpu_i))*NUM_IRQ + int'($past(cmd_data_i[ID_W-1:0]))]);

    a_r8_all_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (sgi_ok && cmd_data_i[SGI_FILT_LSB +: 2] == 2'd3)
        |=> (pend_set_o[int'($past(cmd_data_i[ID_W-1:0]))]
             && pend_set_o[(NUM_CPU-1)*NUM_IRQ + int'($past(cmd_data_i[ID_W-1:0]))]));

endmodule

bind irq_latch_dispatch irq_latch_dispatch_chk #(
    .NUM_CPU(NUM_CPU), .NUM_SHARED(NUM_SHARED), .NUM_IRQ(NUM_IRQ),
    .CPU_W(CPU_W), .ID_W(ID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .shr_line_i(shr_line_i), .prv_line_i(prv_line_i),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_cpu_i(cmd_cpu_i),
    .cmd_id_i(cmd_id_i), .cmd_data_i(cmd_data_i), .pend_set_o(pend_set_o)
);

// File: tb/irq_latch_dispatch_bench.sv
// Scoreboard bench: driver tasks queue expected request vectors with the
// cycle they are due; a monitor compares every due or nonzero cycle.
module irq_latch_dispatch_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCPU  = 4;
    localparam int NSHR  = 32;
    localparam int NPRV  = 32;
    localparam int NIRQ  = NSHR + NPRV;
    localparam int OUTW  = NCPU * NIRQ;
    localparam int CPUW  = 2;
    localparam int IDW   = 6;
    localparam int WATCHDOG = 20000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NSHR-1:0]  shr_line;
    logic [NCPU*NPRV-1:0] prv_line;
    logic             cmd_valid;
    logic [2:0]       cmd_op;
    logic [CPUW-1:0]  cmd_cpu;
    logic [IDW-1:0]   cmd_id;
    logic [31:0]      cmd_data;
    logic [OUTW-1:0]  pend;

    typedef struct {
        int              due;
        logic [OUTW-1:0] vec;
        string           tag;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    irq_latch_dispatch u_irq_latch_dispatch (
        .clk(clk), .rst_n(rst_n), .shr_line_i(shr_line), .prv_line_i(prv_line),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_cpu_i(cmd_cpu),
        .cmd_id_i(cmd_id), .cmd_data_i(cmd_data), .pend_set_o(pend)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [OUTW-1:0] bitv(int c, int i);
        logic [OUTW-1:0] v;
        v = '0;
        v[c*NIRQ + i] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] sgi_word(int filt, int list, int id);
        return (32'(filt) << 24) | (32'(list) << 16) | 32'(id);
    endfunction

    task automatic push(int lat, logic [OUTW-1:0] v, string tag);
        exp_t e;
        e.due = cyc + lat;
        e.vec = v;
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic [2:0] op, int c, int id, logic [31:0] d,
                        logic [OUTW-1:0] expv, string tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_cpu = CPUW'(c);
        cmd_id = IDW'(id); cmd_data = d;
        push(1, expv, tag);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = '0;
        idle(3);
    endtask

    task automatic prv_drive(int c, int i, bit v, logic [OUTW-1:0] expv, string tag);
        @(negedge clk);
        prv_line[c*NPRV + i] = v;
        push(3, expv, tag);
        idle(5);
    endtask

    task automatic shr_drive(int n, bit v, logic [OUTW-1:0] expv, string tag);
        @(negedge clk);
        shr_line[n] = v;
        push(3, expv, tag);
        idle(5);
    endtask

    task automatic quiet(int n, string tag);
        for (int k = 1; k <= n; k++) push(k, '0, tag);
        idle(n);
    endtask

    // Monitor: pop due items and compare against the output
    always @(negedge clk) begin
        logic [OUTW-1:0] exp_v;
        string tg;
        bit hit;
        if (rst_n && !done) begin
            exp_v = '0; tg = "R4"; hit = 1'b0;
            for (int k = sbq.size() - 1; k >= 0; k--) begin
                if (sbq[k].due == cyc) begin
                    exp_v |= sbq[k].vec;
                    tg = sbq[k].tag;
                    hit = 1'b1;
                    sbq.delete(k);
                end
            end
            if (hit || pend != '0) begin
                checks++;
                if (pend !== exp_v) begin
                    errors++;
                    $display("FAIL %s: cycle %0d actual %h expected %h", tg, cyc, pend, exp_v);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; shr_line = '0; prv_line = '0;
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_cpu = '0; cmd_id = '0; cmd_data = '0;
        idle(4);
        checks++;
        if (pend !== '0) begin
            errors++;
            $display("FAIL R1: actual %h expected 0 in reset", pend);
        end
        rst_n = 1'b1;
        quiet(3, "R1");

        // R2 / R1: private ID 5 on CPU 1 is enabled and edge after reset
        prv_drive(1, 5, 1'b1, bitv(1, 5), "R2");
        // R5: held high, no further request
        quiet(4, "R5");
        // R4: falling edge raises nothing
        prv_drive(1, 5, 1'b0, '0, "R4");
        // R1 / R4: private ID 20 is level and disabled after reset
        prv_drive(2, 20, 1'b1, '0, "R1");
        prv_drive(2, 20, 1'b0, '0, "R4");
        // R7: config write with edge flag 0 to a private ID still forces edge
        send(3'd3, 2, 20, 32'h0000_0001, '0, "R7");
        prv_drive(2, 20, 1'b1, bitv(2, 20), "R7");
        prv_drive(2, 20, 1'b0, '0, "R4");

        // R10: target mask of ID 40 = CPUs 0 and 2
        send(3'd4, 0, 40, 32'h0000_0005, '0, "R10");
        // R4: level-triggered and disabled shared rise raises nothing
        shr_drive(8, 1'b1, '0, "R4");
        // R6: enable set while level is high
        send(3'd1, 0, 40, 32'h0, bitv(0, 40) | bitv(2, 40), "R6");
        // R3: enabled level rise goes to the target CPUs
        shr_drive(8, 1'b0, '0, "R4");
        shr_drive(8, 1'b1, bitv(0, 40) | bitv(2, 40), "R3");
        // R9: disable, then a new rise raises nothing
        send(3'd2, 0, 40, 32'h0, '0, "R9");
        shr_drive(8, 1'b0, '0, "R9");
        shr_drive(8, 1'b1, '0, "R9");
        // R7 / R3: edge-triggered shared rise counts while disabled
        send(3'd3, 0, 40, 32'h0000_0002, '0, "R7");
        shr_drive(8, 1'b0, '0, "R4");
        shr_drive(8, 1'b1, bitv(0, 40) | bitv(2, 40), "R3");
        // R10: opcode 6 is ignored, target mask unchanged
        send(3'd6, 0, 40, 32'h0000_0008, '0, "R10");
        shr_drive(8, 1'b0, '0, "R4");
        shr_drive(8, 1'b1, bitv(0, 40) | bitv(2, 40), "R10");

        // R8: software interrupt filters, requester is CPU 2
        send(3'd5, 2, 0, sgi_word(0, 8'h0A, 3), bitv(1, 3) | bitv(3, 3), "R8");
        send(3'd5, 2, 0, sgi_word(0, 8'hF1, 4), bitv(0, 4), "R8");
        send(3'd5, 2, 0, sgi_word(1, 0, 7),
             bitv(0, 7) | bitv(1, 7) | bitv(3, 7), "R8");
        send(3'd5, 2, 0, sgi_word(2, 8'h0F, 9), bitv(2, 9), "R8");
        send(3'd5, 1, 0, sgi_word(3, 0, 50),
             bitv(0, 50) | bitv(1, 50) | bitv(2, 50) | bitv(3, 50), "R8");
        send(3'd5, 2, 0, sgi_word(3, 0, 100), '0, "R8");

        // R6: private level ID 25 on CPU 3, raised then enabled
        prv_drive(3, 25, 1'b1, '0, "R4");
        send(3'd1, 0, 25, 32'h0, '0, "R6");
        send(3'd1, 3, 25, 32'h0, bitv(3, 25), "R6");
        // R9: clearing CPU 3's enable blocks the next level rise
        send(3'd2, 3, 25, 32'h0, '0, "R9");
        prv_drive(3, 25, 1'b0, '0, "R9");
        prv_drive(3, 25, 1'b1, '0, "R9");

        idle(4);
        done = 1'b1;
        if (sbq.size() != 0) begin
            checks++; errors++;
            $display("FAIL R2: actual %0d pending items expected 0", sbq.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule